// File: doc/BRIEF.md
# Write-Once Prescaled Tick Divider

This block derives a slow timing enable for a nonvolatile-memory controller from the fast oscillator clock. Software programs one 8-bit configuration register through a small bus port. The register holds two settings: a select for a fixed divide-by-8 prescaler, and a 6-bit divider value. Once the register has been programmed, the block emits a pulse on `tick_o` that is one oscillator cycle wide, once every N oscillator cycles. N equals (divider value + 1), multiplied by 8 when the prescaler is selected, so N runs from 1 to 512. The pulse is a clock enable and not a generated clock. Software must choose N so that the resulting rate suits the memory. The hardware does not check that choice.

The configuration accepts exactly one write after reset and is then frozen. The top bit of the register is a read-only flag that reports whether this write has happened. The flag also appears on the `cfg_loaded` pin. Two further register addresses are reserved: they read 0 and ignore writes. The bus port is a plain register port with no flow control. A write completes in the cycle in which `bus_sel` and `bus_wr` are high. Read data is combinational from the current address. No back-pressure exists, because every access completes in a single cycle.

Top module: `nvm_tick_divider`

## Requirements
- R1: After reset, `bus_rdata` reads 0 at every address, `cfg_loaded` is 0 and `tick_o` is 0. Read data is 0 whenever `bus_sel` is low.
- R2: Address 0 reads as follows. Bit 7 is the loaded flag. Bit 6 is the prescaler select. Bits 5:0 are the divider value. After a write, bits 6:0 read back the written data.
- R3: Bits 6:0 take the data of the first write to address 0 after reset. Every later write to address 0 leaves them unchanged.
- R4: Write data cannot set or clear bit 7. Bit 7 reads 0 until the first write to address 0, then reads 1 until the next reset. `cfg_loaded` carries the same value.
- R5: A first write to address 0 with all-zero data still locks the register and sets the loaded flag.
- R6: `tick_o` stays 0 while the loaded flag is 0.
- R7: With bit 6 at 0, `tick_o` is high for one cycle in every N = divider value + 1 cycles. With N = 1, it is high in every cycle.
- R8: With bit 6 at 1, the period is N = 8 × (divider value + 1). The largest period is 512, reached with data 0x7F.
- R9: Addresses 1 and 2 read 0 and ignore writes. A write to either address does not lock the configuration.
- R10: Counting restarts at the locking write. If that write is sampled at clock edge 0, `tick_o` is high after edges N, 2N, 3N and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 2 | Register address: 0 is configuration, 1 and 2 are reserved |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, 0 when not selected |
| cfg_loaded | output | 1 | Configuration has been written since reset |
| tick_o | output | 1 | One-cycle enable at the divided rate |

## Verification
The bench builds the block with its default parameters: a 6-bit divider and a prescaler of 8. With these values the whole ratio range, from 1 to 512, is reachable within a few thousand cycles. The bench resets between scenarios so that each one gets a fresh write-once window. The scenarios cover the smallest period, two middle periods, the largest period and an all-zero locking write. They also cover late writes that must be ignored, and writes to the reserved addresses made before and after locking.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int DIV_W  = 6;
  localparam int REG_W  = DIV_W + 2;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CFG   = 2'd0,
    ADDR_RSV_A = 2'd1,
    ADDR_RSV_B = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             pre_en;
    logic [DIV_W-1:0] div_val;
  } div_cfg_t;
endpackage

// File: rtl/ckdiv_cfg_reg.sv
module ckdiv_cfg_reg
  import ckdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output div_cfg_t          cfg,
  output logic              loaded,
  output logic              load_now
);
  div_cfg_t cfg_q;
  logic     loaded_q;
  logic     cfg_hit;

  assign cfg_hit  = bus_sel && bus_wr && (reg_addr_e'(bus_addr) == ADDR_CFG);
  assign load_now = cfg_hit && !loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
    end else if (load_now) begin
      cfg_q    <= div_cfg_t'(bus_wdata[REG_W-2:0]);
      loaded_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (reg_addr_e'(bus_addr))
        ADDR_CFG: bus_rdata = {loaded_q, cfg_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign cfg    = cfg_q;
  assign loaded = loaded_q;

  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> $stable(cfg_q));

  a_r4_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> loaded_q);

  a_r9_rsv_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded_q && bus_sel && bus_wr && (bus_addr != ADDR_CFG)) |=> !loaded_q);
endmodule

// File: rtl/ckdiv_prescaler.sv
module ckdiv_prescaler #(
  parameter int PRE_RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic pre_en,
  output logic stage_tick
);
  localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

  generate
    if (PRE_RATIO > 1) begin : gen_pre
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);
      logic [PRE_W-1:0] pcnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pcnt <= '0;
        end else if (restart) begin
          pcnt <= '0;
        end else if (run && pre_en) begin
          pcnt <= (pcnt == PRE_LAST) ? '0 : pcnt + 1'b1;
        end
      end

      assign stage_tick = run && (pre_en ? (pcnt == PRE_LAST) : 1'b1);

      a_r8_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_tick && pre_en) |=> !stage_tick);
    end else begin : gen_bypass
      assign stage_tick = run;
    end
  endgenerate
endmodule

// File: rtl/ckdiv_counter.sv
module ckdiv_counter
  import ckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             stage_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_o
);
  logic [DIV_W-1:0] dcnt;
  logic             tick_q;
  logic             at_end;

  assign at_end = (dcnt == div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt   <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= run && stage_tick && at_end;
      if (restart) begin
        dcnt <= '0;
      end else if (run && stage_tick) begin
        dcnt <= at_end ? '0 : dcnt + 1'b1;
      end
    end
  end

  assign tick_o = tick_q;

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (dcnt <= div_val));

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick_q);
endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider
  import ckdiv_pkg::*;
#(
  parameter int PRE_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              cfg_loaded,
  output logic              tick_o
);
  div_cfg_t cfg;
  logic     loaded;
  logic     load_now;
  logic     stage_tick;

  ckdiv_cfg_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg),
    .loaded    (loaded),
    .load_now  (load_now)
  );

  ckdiv_prescaler #(.PRE_RATIO(PRE_RATIO)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (loaded),
    .restart    (load_now),
    .pre_en     (cfg.pre_en),
    .stage_tick (stage_tick)
  );

  ckdiv_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (loaded),
    .restart    (load_now),
    .stage_tick (stage_tick),
    .div_val    (cfg.div_val),
    .tick_o     (tick_o)
  );

  assign cfg_loaded = loaded;

  a_r7_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (cfg.pre_en || (cfg.div_val != '0))) |=> !tick_o);

  a_r4_pin_matches: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loaded |=> cfg_loaded);
endmodule

// File: tb/nvm_tick_divider_tb_top.sv
module nvm_tick_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cfg_loaded;
  logic       tick_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_tag = "R1";

  // behavioural reference state
  bit       m_loaded = 1'b0;
  bit [6:0] m_cfg    = 7'd0;
  int       m_cyc    = 0;

  always #10 clk = ~clk;

  nvm_tick_divider dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_loaded (cfg_loaded),
    .tick_o     (tick_o)
  );

  function automatic int ratio();
    return (int'(m_cfg[5:0]) + 1) * (m_cfg[6] ? 8 : 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loaded = 1'b0;
      m_cfg    = 7'd0;
      m_cyc    = 0;
    end else if (!m_loaded && bus_sel && bus_wr && bus_addr == 2'd0) begin
      m_loaded = 1'b1;
      m_cfg    = bus_wdata[6:0];
      m_cyc    = 0;
    end else if (m_loaded) begin
      m_cyc = m_cyc + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // compare against the model in the middle of every cycle
  always @(negedge clk) begin
    if (!done) begin
      bit    exp_tick;
      int    exp_rd;
      string ttag;
      exp_tick = m_loaded && m_cyc > 0 && (m_cyc % ratio()) == 0;
      exp_rd   = (bus_sel && bus_addr == 2'd0) ? {m_loaded, m_cfg} : 0;
      if (!rst_n) ttag = "R1";
      else if (!m_loaded) ttag = "R6";
      else if (m_cyc <= ratio()) ttag = "R10";
      else if (m_cfg[6]) ttag = "R8";
      else ttag = "R7";
      chk(ttag, tick_o, exp_tick);
      chk(cur_tag, bus_rdata, exp_rd);
      chk("R4", cfg_loaded, m_loaded);
    end
  end

  task automatic drive_idle(int n, logic [1:0] a);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #3;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    end
  endtask

  task automatic drive_wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #3;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #3;
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic do_reset();
    @(posedge clk); #3;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
    cur_tag = "R1";
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
  endtask

  initial begin
    // scenario A: reset state, reserved addresses, first write, late writes
    do_reset();
    drive_idle(2, 2'd1);
    drive_idle(2, 2'd2);
    cur_tag = "R9";
    drive_wr(2'd1, 8'hFF);
    drive_wr(2'd2, 8'h7F);
    drive_idle(3, 2'd1);
    drive_idle(3, 2'd0);
    cur_tag = "R2";
    drive_wr(2'd0, 8'h85);         // pre off, div 5 -> period 6
    drive_idle(40, 2'd0);
    cur_tag = "R3";
    drive_wr(2'd0, 8'h7F);         // must be ignored
    drive_wr(2'd0, 8'h00);
    drive_idle(30, 2'd0);
    cur_tag = "R9";
    drive_wr(2'd1, 8'h55);
    drive_idle(4, 2'd2);
    drive_idle(4, 2'd0);

    // scenario B: all-zero locking write, period 1
    do_reset();
    drive_idle(3, 2'd0);
    cur_tag = "R5";
    drive_wr(2'd0, 8'h00);
    drive_idle(10, 2'd0);
    cur_tag = "R3";
    drive_wr(2'd0, 8'h3F);
    drive_idle(10, 2'd0);

    // scenario C: prescaler with div 1 -> period 16
    do_reset();
    cur_tag = "R8";
    drive_wr(2'd0, 8'h41);
    drive_idle(70, 2'd0);

    // scenario D: largest period 512
    do_reset();
    cur_tag = "R8";
    drive_wr(2'd0, 8'h7F);
    drive_idle(1100, 2'd0);

    // scenario E: top data bit set in the first write, pre off, div 63
    do_reset();
    drive_idle(2, 2'd0);
    cur_tag = "R4";
    drive_wr(2'd0, 8'hBF);
    drive_idle(140, 2'd0);
    cur_tag = "R7";
    drive_wr(2'd0, 8'h41);
    drive_idle(20, 2'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule